// File: doc/BRIEF.md
# Replay FIFO with Half-Occupancy Flag

This block is a single-clock first-in-first-out buffer for 9-bit words. It is meant to sit between a producer and a consumer that run at different average rates. The ninth bit lets a parity or control bit travel with each byte. Storage is a two-port memory addressed by a write pointer and a read pointer. Both pointers step through the storage and wrap to zero after the last entry. Full, empty and half-occupied are therefore set by the distance between the pointers, never by where the pointers are.

Accesses that make no sense are dropped: a write into a full buffer is ignored, and so is a read from an empty one. Each word stays in its location after it is read. Pulsing the active-low rewind input moves only the read pointer back to location zero, so the words written since reset can be read out again. This works when fewer than a full depth of words have been written since the last reset. All status outputs are active-low and registered.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both pointers are at location zero and the outputs read `empty_n`=0, `full_n`=1, `half_n`=1 and `rd_data`=0.
- R2: Words come out in the order they were written. `rd_data` shows the word in the cycle after an accepted read. It keeps its value in every cycle where no read is accepted.
- R3: A write while `full_n` is low is ignored. It changes neither the stored words nor the occupancy.
- R4: A read while `empty_n` is low is ignored. `rd_data` keeps its value and the read pointer does not move.
- R5: `full_n` goes low in the cycle after the write that fills the last free location. It goes high in the cycle after the next accepted read.
- R6: `empty_n` goes low in the cycle after the read of the last stored word. It goes high in the cycle after the next accepted write.
- R7: `half_n` is low exactly when more than DEPTH/2 words are stored. It therefore falls after the write that takes the occupancy from DEPTH/2 to DEPTH/2+1, and rises after the read that brings it back to DEPTH/2.
- R8: When a read and a write are requested in the same cycle and the buffer is neither empty nor full, both are accepted and the occupancy does not change. When the buffer is empty, only the write is accepted. When it is full, only the read is accepted.
- R9: Both pointers wrap from location DEPTH-1 to location zero, and the word order is kept across the wrap.
- R10: A cycle with `rewind_n` low moves the read pointer to location zero and leaves the write pointer unchanged. A read requested in that cycle is ignored, while a write in that cycle is still accepted. The occupancy becomes the number of words written since reset, and the reads that follow return those words again from the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH (9) | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH (9) | Registered read word |
| rewind_n | input | 1 | Replay request, active low: rewinds the read pointer |
| full_n | output | 1 | Low when every location holds an unread word |
| empty_n | output | 1 | Low when no unread word is stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The bench builds the block with DEPTH=16 and the default word width of 9. With that depth a few dozen cycles are enough to fill the buffer completely, cross the half threshold in both directions and wrap both pointers many times. The random phase can therefore keep hitting writes into a full buffer, reads from an empty buffer, and rewinds issued before the first wrap. All of this is compared against a storage and pointer model kept in the bench.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
    localparam int WORD_W = 9;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic half_n;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{full_n: 1'b1, empty_n: 1'b0, half_n: 1'b1};
endpackage

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl #(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic                       rd_req,
    input  logic                       rewind_n,
    output logic                       wr_acc,
    output logic                       rd_acc,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output rfifo_pkg::flags_t          flags
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        rfifo_pkg::flags_t fl;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  is_full, is_empty;

    assign is_full  = (st_q.cnt == CW'(DEPTH));
    assign is_empty = (st_q.cnt == '0);
    assign wr_acc   = wr_req && !is_full;
    assign rd_acc   = rd_req && !is_empty && rewind_n;

    always_comb begin
        st_d = st_q;
        if (wr_acc) begin
            st_d.wp = st_q.wp + AW'(1);
        end
        if (!rewind_n) begin
            // replay: read side restarts, occupancy is the write distance from zero
            st_d.rp  = '0;
            st_d.cnt = {1'b0, st_q.wp} + CW'(wr_acc);
        end else begin
            if (rd_acc) begin
                st_d.rp = st_q.rp + AW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(wr_acc) - CW'(rd_acc);
        end
        st_d.fl.full_n  = !(st_d.cnt == CW'(DEPTH));
        st_d.fl.empty_n = !(st_d.cnt == '0);
        st_d.fl.half_n  = !(st_d.cnt > CW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp  <= '0;
            st_q.rp  <= '0;
            st_q.cnt <= '0;
            st_q.fl  <= rfifo_pkg::FLAGS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wp;
    assign rd_addr = st_q.rp;
    assign flags   = st_q.fl;
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = rfifo_pkg::WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = rfifo_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rewind_n,
    output logic             full_n,
    output logic             empty_n,
    output logic             half_n
);
    localparam int AW = $clog2(DEPTH);

    logic              wr_acc, rd_acc;
    logic [AW-1:0]     wr_addr, rd_addr;
    rfifo_pkg::flags_t flags;

    rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_en),
        .rd_req   (rd_en),
        .rewind_n (rewind_n),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .flags    (flags)
    );

    rfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_acc),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign full_n  = flags.full_n;
    assign empty_n = flags.empty_n;
    assign half_n  = flags.half_n;
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
    parameter int WIDTH = rfifo_pkg::WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rewind_n,
    input logic [WIDTH-1:0] rd_data,
    input logic             full_n,
    input logic             empty_n,
    input logic             half_n
);
    // R2
    read_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && rewind_n) |=> $stable(rd_data));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_en && !rd_en && rewind_n) |=> !full_n);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_en && !wr_en && rewind_n) |=> (!empty_n && $stable(rd_data)));

    // R5
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_en && rewind_n) |=> full_n);

    // R6
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wr_en && rewind_n) |=> empty_n);

    // R7
    full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));
endmodule

bind replay_fifo replay_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rewind_n (rewind_n),
    .rd_data  (rd_data),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .half_n   (half_n)
);

// File: tb/tb_replay_fifo.sv
module tb_replay_fifo;
    localparam int D = 16;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         rewind_n = 1'b1;
    logic [W-1:0] rd_data;
    logic         full_n, empty_n, half_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_mem [D];
    int           m_wp = 0, m_rp = 0, m_cnt = 0, m_written = 0;
    logic [W-1:0] m_q = '0;

    replay_fifo #(.DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rewind_n(rewind_n),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
    );

    always #5 clk = ~clk;

    function automatic logic exp_full_n();  return !(m_cnt == D);     endfunction
    function automatic logic exp_empty_n(); return !(m_cnt == 0);     endfunction
    function automatic logic exp_half_n();  return !(m_cnt > D / 2);  endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rd_data", int'(rd_data), int'(m_q));
        chk(tag, "full_n", int'(full_n), int'(exp_full_n()));
        chk(tag, "empty_n", int'(empty_n), int'(exp_empty_n()));
        chk(tag, "half_n", int'(half_n), int'(exp_half_n()));
    endtask

    // one clock: drive at the falling edge, update the model at the rising edge, sample at the next falling edge
    task automatic step(input logic we, input logic [W-1:0] wd, input logic re, input logic rt);
        bit wa, ra;
        int old_wp;
        wr_en = we; wr_data = wd; rd_en = re; rewind_n = !rt;
        @(posedge clk);
        wa = we && (m_cnt != D);
        ra = re && (m_cnt != 0) && !rt;
        old_wp = m_wp;
        if (ra) begin
            m_q = m_mem[m_rp];
            m_rp = (m_rp + 1) % D;
        end
        if (wa) begin
            m_mem[m_wp] = wd;
            m_wp = (m_wp + 1) % D;
            m_written++;
        end
        if (rt) begin
            m_rp = 0;
            m_cnt = old_wp + int'(wa);
        end else begin
            m_cnt = m_cnt + int'(wa) - int'(ra);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; rd_en = 0; rewind_n = 1;
        @(negedge clk); @(negedge clk);
        // R1 values while reset is held
        chk("R1", "empty_n in reset", int'(empty_n), 0);
        chk("R1", "full_n in reset", int'(full_n), 1);
        chk("R1", "half_n in reset", int'(half_n), 1);
        chk("R1", "rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        m_wp = 0; m_rp = 0; m_cnt = 0; m_written = 0; m_q = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        @(negedge clk);
        do_reset();
        step(0, '0, 0, 0);
        check_all("R1");

        // R4: read from empty is dropped
        step(0, '0, 1, 0);
        check_all("R4");

        // R6 / R2: first write releases empty, then read returns it
        step(1, 9'h1A5, 0, 0);
        check_all("R6");
        step(0, '0, 1, 0);
        check_all("R2");
        check_all("R6");

        // fill to the half threshold and past it: R7
        for (int i = 0; i < D / 2; i++) begin
            step(1, 9'(i + 9'h40), 0, 0);
        end
        check_all("R7");
        step(1, 9'h0F0, 0, 0);
        check_all("R7");

        // fill to full: R5, then overfill: R3
        while (m_cnt < D) step(1, 9'($urandom), 0, 0);
        check_all("R5");
        step(1, 9'h1FF, 0, 0);
        check_all("R3");
        // R8 with full buffer: only the read is taken
        step(1, 9'h111, 1, 0);
        check_all("R8");
        check_all("R5");
        step(1, 9'h122, 1, 0);
        check_all("R8");

        // drain, crossing the half threshold downward, then an empty read: R7, R4, R9
        while (m_cnt > 0) begin
            step(0, '0, 1, 0);
            check_all("R9");
        end
        check_all("R6");
        step(0, '0, 1, 0);
        check_all("R4");
        // R8 with empty buffer: only the write is taken
        step(1, 9'h0AB, 1, 0);
        check_all("R8");

        // replay after fresh reset: R10
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 9'(9'h100 + i), 0, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
        step(0, '0, 1, 1);
        check_all("R10");
        for (int i = 0; i < 5; i++) begin
            step(0, '0, 1, 0);
            check_all("R10");
        end
        step(1, 9'h055, 0, 1);
        check_all("R10");

        // random traffic: R2, R8, R9, R10
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            bit rt;
            rt = (($urandom % 40) == 0) && (m_written < D - 1);
            step(($urandom % 3) != 0, 9'($urandom), ($urandom % 2) == 0, rt);
            check_all(rt ? "R10" : "R2");
            if ((n % 700) == 699) do_reset();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule